// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

A multi-cycle multiplier for two's-complement operands of width W (default 32). Raising `start` while the unit is idle captures both operands. The unit then runs exactly W iterations, one per clock. Each iteration looks at two bits: the low bit of a 2W-bit working register and a single trailing bit kept to its right.

From that pair the unit picks one action: subtract the multiplicand from the upper half, add it, or do no arithmetic. The combined register, trailing bit included, then shifts right by one place and keeps its sign. Negative operands therefore need no conversion before or after the run.

At reset and at each accepted start, the working register is set up with zeros in the upper half, the multiplier in the lower half and a cleared trailing bit. When the last iteration finishes, `done` pulses for one cycle. The 2W-bit signed product stays on `product` until another operation is accepted.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset `busy`, `done` and `product` are all zero.
- R2: When `start` is high at a rising edge while `busy` and `done` are low, the operation is accepted and `busy` is high from that edge onward.
- R3: An operation accepted at edge t runs for exactly W iterations. `busy` stays high and `done` stays low through edge t+W-1. At edge t+W, `busy` falls and `done` rises.
- R4: The value on `product`, read as a 2W-bit two's-complement number when `done` is high, equals the signed product of the multiplicand and multiplier captured at the accepting edge, for every operand pair.
- R5: `done` is high for exactly one cycle per operation.
- R6: Between the `done` pulse and the next accepted start, `product` does not change, even when the operand inputs change.
- R7: A `start` that arrives while an operation is running is ignored. The running result and its completion time are unchanged.
- R8: The operands are captured only at the accepting edge. Changing `mcand` or `mplier` during the run has no effect on the result.
- R9: The most negative value is handled for both operands: (-2^(W-1)) times (-2^(W-1)) gives +2^(2W-2), and (-2^(W-1)) times 1 gives -2^(W-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new multiplication; taken only when idle |
| mcand | input | W | Multiplicand, two's complement |
| mplier | input | W | Multiplier, two's complement |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse marking a finished product |
| product | output | 2W | Signed 2W-bit product |

## Verification
Counting from the edge that accepts `start`, `busy` is due one cycle later. `done` and the final `product` are due W cycles after acceptance, and `done` must fall again one cycle after that. The bench drives inputs on falling edges and samples on the falling edge that follows each due edge. It checks that `done` stays low on every intermediate falling edge, that it is high on falling edge W, and that it is low again on falling edge W+1, with the product unchanged at that point. Each run scrambles the operand inputs right after acceptance, and some runs also pulse `start` mid-run, so that the R7 and R8 checks are folded into the R3 and R4 timing checks.

// File: rtl/booth_seq_mult.sv
`timescale 1ns/1ps
module booth_seq_mult #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = $clog2(W + 1);

  logic [2*W-1:0]  acc_q;
  logic            tail_q;
  logic [W-1:0]    mc_q;
  logic [CW-1:0]   step_q;
  logic            busy_q;
  logic            done_q;

  logic signed [W:0] hi_x;
  logic signed [W:0] mc_x;
  logic signed [W:0] sum;
  logic              accept;
  logic              last;

  assign hi_x   = {acc_q[2*W-1], acc_q[2*W-1:W]};
  assign mc_x   = {mc_q[W-1], mc_q};
  assign accept = start && !busy_q;
  assign last   = (step_q == CW'(W - 1));

  always_comb begin
    case ({acc_q[0], tail_q})
      2'b10:   sum = hi_x - mc_x;
      2'b01:   sum = hi_x + mc_x;
      default: sum = hi_x;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tail_q <= 1'b0;
      mc_q   <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        acc_q  <= {sum, acc_q[W-1:1]};
        tail_q <= acc_q[0];
        step_q <= step_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (accept) begin
        acc_q  <= {{W{1'b0}}, mplier};
        tail_q <= 1'b0;
        mc_q   <= mcand;
        step_q <= '0;
        busy_q <= 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign product = acc_q;

  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q);

  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (step_q < CW'(W)));

  assert_done_after_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(busy_q) && !busy_q));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(product));

  assert_ignore_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> $stable(mc_q));
endmodule

// File: tb/test_booth_seq_mult.sv
`timescale 1ns/1ps
module test_booth_seq_mult;
  localparam int W = 6;
  localparam int LO = -(1 << (W - 1));
  localparam int HI = (1 << (W - 1)) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  booth_seq_mult #(.W(W)) i_booth_seq_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mplier(mplier), .busy(busy), .done(done), .product(product)
  );

  function automatic longint prod_s();
    return longint'($signed(product));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_one(input int a, input int b, input bit poke, input int idle);
    longint exp;
    bit early;
    exp = longint'(a) * longint'(b);
    @(negedge clk);
    start  = 1'b1;
    mcand  = W'(a);
    mplier = W'(b);
    @(negedge clk);
    start  = 1'b0;
    mcand  = ~mcand;
    mplier = mplier ^ W'(5);
    chk(busy === 1'b1, "R2 busy after accept", longint'(busy), 1);
    early = 1'b0;
    for (int k = 1; k < W; k++) begin
      @(negedge clk);
      if (poke && k == 1) begin
        start  = 1'b1;
        mcand  = W'(a + 3);
        mplier = W'(b - 1);
      end
      if (poke && k == 2) start = 1'b0;
      if (done !== 1'b0 || busy !== 1'b1) early = 1'b1;
    end
    start = 1'b0;
    chk(!early, poke ? "R3/R7 run length" : "R3 run length", longint'(early), 0);
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, "R3 done at W", longint'({busy, done}), 1);
    chk(prod_s() == exp, poke ? "R4/R7/R8 product" : "R4/R8 product", prod_s(), exp);
    @(negedge clk);
    chk(done === 1'b0, "R5 done pulse width", longint'(done), 0);
    for (int k = 0; k < idle; k++) begin
      mcand  = W'(k * 7);
      mplier = W'(k * 11 + 1);
      @(negedge clk);
    end
    chk(prod_s() == exp, "R6 product held", prod_s(), exp);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      finished = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset flags", longint'({busy, done}), 0);
    chk(product === '0, "R1 reset product", longint'(product), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && product === '0, "R1 after release", longint'(product), 0);

    run_one(7, -3, 1'b0, 4);
    run_one(-7, -3, 1'b1, 4);
    run_one(LO, LO, 1'b0, 3);
    chk(prod_s() == longint'(1) << (2 * W - 2), "R9 min*min", prod_s(), longint'(1) << (2 * W - 2));
    run_one(LO, 1, 1'b1, 2);
    chk(prod_s() == longint'(LO), "R9 min*1", prod_s(), longint'(LO));
    run_one(HI, LO, 1'b0, 1);

    for (int a = LO; a <= HI; a++)
      for (int b = LO; b <= HI; b++)
        run_one(a, b, ((a + b) % 7) == 0, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule